// File: doc/BRIEF.md
# Codec-to-Controller Serial Frame Builder

This block sits on the codec side of an AC'97-style serial link. It builds each 256-bit input frame and shifts it out MSB first on the serial data line toward the controller. A frame has a 16-bit tag slot followed by twelve 20-bit slots. The block fills four of them:

- the tag slot;
- the status address slot, which echoes a register index and carries the per-channel sample-request bits;
- the status data slot, which returns the register contents;
- the left record slot, which holds the ADC sample.

Every other slot is sent as zeros and tagged invalid.

A read request may arrive at any time during frame N. It is held in a pending register. At the start of frame N+1, the pending read is moved into that frame's snapshot, so the echo and the returned data appear exactly once. The register file, the ADC and the rate converter are outside this block. They present their values at the input ports, and all frame content is sampled on the clock edge that starts the frame.

A small state machine walks the frame. Its states are:
- `S_WAIT`: idle, line low.
- `S_TAG`: the tag slot.
- `S_ADDR`: the status address slot.
- `S_DATA`: the status data slot.
- `S_PCM`: the left record slot.
- `S_FILL`: the zero-filled slots 4 to 12.

Its transitions are:
- frame start, from any state, goes to `S_TAG`.
- Each slot whose bit counter reaches zero moves on to the next slot, in the order `S_TAG`, `S_ADDR`, `S_DATA`, `S_PCM`, `S_FILL`.
- The end of `S_FILL` returns to `S_WAIT`.

Top module: `acl_in_framer`

## Requirements
- R1: After reset, and until the first frame start, `sdin` is 0.
- R2: A frame start is an edge that samples `sync` high when it was low at the previous edge. Frame bit 0 is driven after that edge, and bit k after the k-th following edge. A frame is 256 bits long, and each slot is sent most significant bit first.
- R3: The tag slot is 16 bits. Its bit 15 is frame-valid, bit 14 is the status address tag, bit 13 is the status data tag and bit 12 is the left record tag. Bits 11:0 are 0.
- R4: A read request (`rd_req_vld` high for one or more edges) in frame N puts the last requested index into bits 18:12 of the status address slot of frame N+1. It also sets tags 14 and 13 in that frame. Bit 19 of the slot is always 0.
- R5: The status data slot carries `rd_data` (sampled at the start of frame N+1) in bits 19:4, and zeros in bits 3:0. It is all zero when no read is echoed.
- R6: A read is returned in one frame only. A later frame with no new read has tags 14 and 13 at 0, an index field of 0 and a zero status data slot.
- R7: With `vra_en` at 1, status address bit 11 is the inverse of `need_left` and bit 10 is the inverse of `need_right`. A value of 0 means "send a sample next frame". Bits 9:0 are always 0.
- R8: With `vra_en` at 0, status address bits 11 and 10 are both 0 in every frame.
- R9: The left record slot holds `adc_left` in bits 19:2 and zeros in bits 1:0, with tag 12 set. When `adc_off` is 1, tag 12 is 0 and the slot is all zero.
- R10: Slots 4 through 12 (frame bits 76 to 255) are always 0.
- R11: Frame-valid is 1 exactly when `codec_ready` is 1 or any slot tag is set.
- R12: A frame start in the middle of a frame restarts at frame bit 0 with a fresh snapshot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bit_clk | input | 1 | Serial bit clock; outputs change on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync | input | 1 | Frame sync from the controller |
| codec_ready | input | 1 | Codec ready indication feeding frame-valid |
| rd_req_vld | input | 1 | Register read requested in the current output frame |
| rd_req_idx | input | 7 | Index of the requested register |
| rd_data | input | 16 | Register contents for the pending read |
| adc_left | input | 18 | Left ADC sample, two's complement |
| adc_off | input | 1 | ADC powered down |
| vra_en | input | 1 | Variable-rate mode enable |
| need_left | input | 1 | Left PCM sample needed next frame |
| need_right | input | 1 | Right PCM sample needed next frame |
| sdin | output | 1 | Serial frame data toward the controller |

## Verification
A corrupted state or bit counter shows up on the line within one slot. If a slot boundary slips, a padding zero is replaced by a data bit, or data bits appear in the fill region, so the next frame that is deserialized disagrees with the expected slot words. A stale pending-read flag shows within one frame: either an echo repeats in a frame after the one that returned it, or an expected echo is missing. A wrong request-bit polarity or a missing VRA gate is visible in the very frame in which the `need_*` inputs change.

// File: rtl/acl_pkg.sv
package acl_pkg;
    typedef enum logic [2:0] {
        S_WAIT,
        S_TAG,
        S_ADDR,
        S_DATA,
        S_PCM,
        S_FILL
    } fstate_t;
endpackage

// File: rtl/acl_seq.sv
module acl_seq
    import acl_pkg::*;
#(
    parameter int TAG_BITS   = 16,
    parameter int SLOT_BITS  = 20,
    parameter int FRAME_BITS = 256,
    localparam int CNT_W     = $clog2(FRAME_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output fstate_t          st,
    output logic [CNT_W-1:0] cnt
);
    localparam int FILL_BITS = FRAME_BITS - TAG_BITS - 3 * SLOT_BITS;
    localparam logic [CNT_W-1:0] TAG_TOP  = CNT_W'(TAG_BITS - 1);
    localparam logic [CNT_W-1:0] SLOT_TOP = CNT_W'(SLOT_BITS - 1);
    localparam logic [CNT_W-1:0] FILL_TOP = CNT_W'(FILL_BITS - 1);

    fstate_t          st_n;
    logic [CNT_W-1:0] cnt_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= S_WAIT;
            cnt <= '0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
        end
    end

    always_comb begin
        st_n  = st;
        cnt_n = cnt;
        if (start) begin
            st_n  = S_TAG;
            cnt_n = TAG_TOP;
        end else begin
            unique case (st)
                S_WAIT: cnt_n = '0;
                S_TAG:
                    if (cnt == '0) begin
                        st_n  = S_ADDR;
                        cnt_n = SLOT_TOP;
                    end else begin
                        cnt_n = cnt - 1'b1;
                    end
                S_ADDR:
                    if (cnt == '0) begin
                        st_n  = S_DATA;
                        cnt_n = SLOT_TOP;
                    end else begin
                        cnt_n = cnt - 1'b1;
                    end
                S_DATA:
                    if (cnt == '0) begin
                        st_n  = S_PCM;
                        cnt_n = SLOT_TOP;
                    end else begin
                        cnt_n = cnt - 1'b1;
                    end
                S_PCM:
                    if (cnt == '0) begin
                        st_n  = S_FILL;
                        cnt_n = FILL_TOP;
                    end else begin
                        cnt_n = cnt - 1'b1;
                    end
                S_FILL:
                    if (cnt == '0) begin
                        st_n  = S_WAIT;
                    end else begin
                        cnt_n = cnt - 1'b1;
                    end
                default: begin
                    st_n  = S_WAIT;
                    cnt_n = '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/acl_snap.sv
module acl_snap #(
    parameter int TAG_BITS  = 16,
    parameter int SLOT_BITS = 20,
    parameter int IDX_W     = 7,
    parameter int DATA_W    = 16,
    parameter int ADC_W     = 18
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 codec_ready,
    input  logic                 rd_req_vld,
    input  logic [IDX_W-1:0]     rd_req_idx,
    input  logic [DATA_W-1:0]    rd_data,
    input  logic [ADC_W-1:0]     adc_left,
    input  logic                 adc_off,
    input  logic                 vra_en,
    input  logic                 need_left,
    input  logic                 need_right,
    output logic [TAG_BITS-1:0]  tag_w,
    output logic [SLOT_BITS-1:0] addr_w,
    output logic [SLOT_BITS-1:0] data_w,
    output logic [SLOT_BITS-1:0] pcm_w
);
    localparam int IDX_LSB = SLOT_BITS - 1 - IDX_W;

    logic                 pend_vld;
    logic [IDX_W-1:0]     pend_idx;
    logic                 echo;
    logic [IDX_W-1:0]     idx_sel;
    logic [TAG_BITS-1:0]  tag_c;
    logic [SLOT_BITS-1:0] addr_c, data_c, pcm_c;

    // Pending read for the frame in progress; consumed by the next frame start.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_vld <= 1'b0;
            pend_idx <= '0;
        end else if (start) begin
            pend_vld <= 1'b0;
        end else if (rd_req_vld) begin
            pend_vld <= 1'b1;
            pend_idx <= rd_req_idx;
        end
    end

    always_comb begin
        echo    = pend_vld | rd_req_vld;
        idx_sel = rd_req_vld ? rd_req_idx : pend_idx;

        addr_c = '0;
        if (echo) addr_c[IDX_LSB +: IDX_W] = idx_sel;
        addr_c[IDX_LSB-1] = vra_en & ~need_left;
        addr_c[IDX_LSB-2] = vra_en & ~need_right;

        data_c = '0;
        if (echo) data_c[SLOT_BITS-1 -: DATA_W] = rd_data;

        pcm_c = '0;
        if (!adc_off) pcm_c[SLOT_BITS-1 -: ADC_W] = adc_left;

        tag_c = '0;
        tag_c[TAG_BITS-2] = echo;
        tag_c[TAG_BITS-3] = echo;
        tag_c[TAG_BITS-4] = ~adc_off;
        tag_c[TAG_BITS-1] = codec_ready | echo | ~adc_off;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tag_w  <= '0;
            addr_w <= '0;
            data_w <= '0;
            pcm_w  <= '0;
        end else if (start) begin
            tag_w  <= tag_c;
            addr_w <= addr_c;
            data_w <= data_c;
            pcm_w  <= pcm_c;
        end
    end
endmodule

// File: rtl/acl_in_framer.sv
module acl_in_framer
    import acl_pkg::*;
#(
    parameter int TAG_BITS   = 16,
    parameter int SLOT_BITS  = 20,
    parameter int FRAME_BITS = 256,
    parameter int IDX_W      = 7,
    parameter int DATA_W     = 16,
    parameter int ADC_W      = 18
) (
    input  logic              bit_clk,
    input  logic              rst_n,
    input  logic              sync,
    input  logic              codec_ready,
    input  logic              rd_req_vld,
    input  logic [IDX_W-1:0]  rd_req_idx,
    input  logic [DATA_W-1:0] rd_data,
    input  logic [ADC_W-1:0]  adc_left,
    input  logic              adc_off,
    input  logic              vra_en,
    input  logic              need_left,
    input  logic              need_right,
    output logic              sdin
);
    localparam int CNT_W   = $clog2(FRAME_BITS);
    localparam int TAG_IW  = $clog2(TAG_BITS);
    localparam int SLOT_IW = $clog2(SLOT_BITS);

    logic                 sync_q;
    logic                 frame_start;
    fstate_t              st;
    logic [CNT_W-1:0]     bit_cnt;
    logic [TAG_BITS-1:0]  tag_w;
    logic [SLOT_BITS-1:0] addr_w, data_w, pcm_w;
    logic                 sdin_c;

    always_ff @(posedge bit_clk or negedge rst_n) begin
        if (!rst_n) sync_q <= 1'b0;
        else        sync_q <= sync;
    end

    assign frame_start = sync & ~sync_q;

    acl_seq #(
        .TAG_BITS  (TAG_BITS),
        .SLOT_BITS (SLOT_BITS),
        .FRAME_BITS(FRAME_BITS)
    ) u_seq (
        .clk  (bit_clk),
        .rst_n(rst_n),
        .start(frame_start),
        .st   (st),
        .cnt  (bit_cnt)
    );

    acl_snap #(
        .TAG_BITS (TAG_BITS),
        .SLOT_BITS(SLOT_BITS),
        .IDX_W    (IDX_W),
        .DATA_W   (DATA_W),
        .ADC_W    (ADC_W)
    ) u_snap (
        .clk        (bit_clk),
        .rst_n      (rst_n),
        .start      (frame_start),
        .codec_ready(codec_ready),
        .rd_req_vld (rd_req_vld),
        .rd_req_idx (rd_req_idx),
        .rd_data    (rd_data),
        .adc_left   (adc_left),
        .adc_off    (adc_off),
        .vra_en     (vra_en),
        .need_left  (need_left),
        .need_right (need_right),
        .tag_w      (tag_w),
        .addr_w     (addr_w),
        .data_w     (data_w),
        .pcm_w      (pcm_w)
    );

    // Output process: pick the current bit of the current slot.
    always_comb begin
        unique case (st)
            S_WAIT:  sdin_c = 1'b0;
            S_TAG:   sdin_c = tag_w[bit_cnt[TAG_IW-1:0]];
            S_ADDR:  sdin_c = addr_w[bit_cnt[SLOT_IW-1:0]];
            S_DATA:  sdin_c = data_w[bit_cnt[SLOT_IW-1:0]];
            S_PCM:   sdin_c = pcm_w[bit_cnt[SLOT_IW-1:0]];
            S_FILL:  sdin_c = 1'b0;
            default: sdin_c = 1'b0;
        endcase
    end

    assign sdin = sdin_c;
endmodule

// File: rtl/acl_chk.sv
module acl_chk
    import acl_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int TAG_BITS  = 16,
    parameter int SLOT_BITS = 20,
    parameter int IDX_W     = 7,
    parameter int DATA_W    = 16,
    parameter int ADC_W     = 18
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input fstate_t          st,
    input logic [CNT_W-1:0] cnt,
    input logic             sdin
);
    localparam logic [CNT_W-1:0] TAG_TOP  = CNT_W'(TAG_BITS - 1);
    localparam logic [CNT_W-1:0] TAG_PAD  = CNT_W'(TAG_BITS - 4);
    localparam logic [CNT_W-1:0] SLOT_TOP = CNT_W'(SLOT_BITS - 1);
    localparam logic [CNT_W-1:0] ADDR_PAD = CNT_W'(SLOT_BITS - IDX_W - 3);
    localparam logic [CNT_W-1:0] DATA_PAD = CNT_W'(SLOT_BITS - DATA_W);
    localparam logic [CNT_W-1:0] PCM_PAD  = CNT_W'(SLOT_BITS - ADC_W);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        st == S_WAIT |-> !sdin);

    p_start_tag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (st == S_TAG && cnt == TAG_TOP));

    p_walk_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st != S_WAIT && !start && cnt != '0) |=> cnt == $past(cnt) - 1'b1);

    p_tag_pad_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_TAG && cnt < TAG_PAD) |-> !sdin);

    p_addr_msb_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_ADDR && cnt == SLOT_TOP) |-> !sdin);

    p_data_pad_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_DATA && cnt < DATA_PAD) |-> !sdin);

    p_addr_pad_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_ADDR && cnt < ADDR_PAD) |-> !sdin);

    p_pcm_pad_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_PCM && cnt < PCM_PAD) |-> !sdin);

    p_fill_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        st == S_FILL |-> !sdin);
endmodule

bind acl_in_framer acl_chk #(
    .CNT_W    (CNT_W),
    .TAG_BITS (TAG_BITS),
    .SLOT_BITS(SLOT_BITS),
    .IDX_W    (IDX_W),
    .DATA_W   (DATA_W),
    .ADC_W    (ADC_W)
) u_chk (
    .clk  (bit_clk),
    .rst_n(rst_n),
    .start(frame_start),
    .st   (st),
    .cnt  (bit_cnt),
    .sdin (sdin)
);

// File: tb/sim_acl_in_framer.sv
`timescale 1ns/1ps
module sim_acl_in_framer;
    logic        bit_clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sync = 1'b0;
    logic        codec_ready = 1'b0;
    logic        rd_req_vld = 1'b0;
    logic [6:0]  rd_req_idx = '0;
    logic [15:0] rd_data = '0;
    logic [17:0] adc_left = '0;
    logic        adc_off = 1'b0;
    logic        vra_en = 1'b0;
    logic        need_left = 1'b0;
    logic        need_right = 1'b0;
    logic        sdin;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    logic [255:0] cap;

    always #2.5 bit_clk = ~bit_clk;

    acl_in_framer u0 (
        .bit_clk(bit_clk), .rst_n(rst_n), .sync(sync), .codec_ready(codec_ready),
        .rd_req_vld(rd_req_vld), .rd_req_idx(rd_req_idx), .rd_data(rd_data),
        .adc_left(adc_left), .adc_off(adc_off), .vra_en(vra_en),
        .need_left(need_left), .need_right(need_right), .sdin(sdin)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Start a frame and capture n bits; optionally pulse a read at bit 100.
    task automatic grab(input int n, input bit do_rd, input logic [6:0] idx);
        cap  = '0;
        sync = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge bit_clk);
            cap[255-i] = sdin;
            if (i == 15) sync = 1'b0;
            if (do_rd && i == 100) begin
                rd_req_vld = 1'b1;
                rd_req_idx = idx;
            end
            if (i == 101) rd_req_vld = 1'b0;
        end
    endtask

    task automatic check_frame(input bit echo, input logic [6:0] idx);
        logic [15:0] e0;
        logic [19:0] e1, e2, e3;
        e0 = {codec_ready | echo | ~adc_off, echo, echo, ~adc_off, 12'h000};
        e1 = {1'b0, echo ? idx : 7'd0, vra_en & ~need_left, vra_en & ~need_right, 10'h000};
        e2 = echo ? {rd_data, 4'h0} : 20'h0;
        e3 = adc_off ? 20'h0 : {adc_left, 2'b00};
        chk("R3/R11 tag slot", 32'(cap[255:240]), 32'(e0));
        chk(vra_en ? "R4/R6/R7 status address" : "R4/R6/R8 status address",
            32'(cap[239:220]), 32'(e1));
        chk("R5/R6 status data", 32'(cap[219:200]), 32'(e2));
        chk("R9 left record", 32'(cap[199:180]), 32'(e3));
        chk("R10 fill slots", 32'(cap[179:0] != '0), 32'd0);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        bit          prev_rd;
        logic [6:0]  prev_idx;
        prev_rd  = 1'b0;
        prev_idx = '0;
        repeat (3) @(negedge bit_clk);
        rst_n = 1'b1;
        // R1: quiet line before any frame start
        for (int i = 0; i < 8; i++) begin
            @(negedge bit_clk);
            chk("R1 idle after reset", 32'(sdin), 32'd0);
        end

        // Sweep VRA, need flags, ADC power and ready; reads on even frames.
        for (int f = 0; f < 20; f++) begin
            bit         rd_now;
            logic [6:0] idx_now;
            vra_en      = f[0];
            need_left   = f[1];
            need_right  = f[2];
            adc_off     = f[3];
            codec_ready = (f % 3) != 0;
            adc_left    = 18'(32'h2_0000 ^ (f * 7919));
            rd_data     = 16'hA000 ^ 16'(prev_idx * 257);
            rd_now      = (f % 2 == 0) && (f < 18);
            idx_now     = 7'((f * 13 + 5) & 7'h7F);
            grab(256, rd_now, idx_now);
            check_frame(prev_rd, prev_idx);
            prev_rd  = rd_now;
            prev_idx = idx_now;
        end

        // R12: restart mid-frame, then check the fresh frame from bit 0.
        vra_en = 1'b1; need_left = 1'b1; need_right = 1'b0;
        adc_off = 1'b0; codec_ready = 1'b0; adc_left = 18'h3_FFFF;
        grab(40, 1'b0, 7'd0);
        adc_left = 18'h1_2345;
        grab(256, 1'b0, 7'd0);
        chk("R12 restarted tag slot", 32'(cap[255:240]), 32'h9000);
        chk("R12 restarted left record", 32'(cap[199:180]), 32'({18'h1_2345, 2'b00}));
        check_frame(1'b0, 7'd0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule